// File: doc/BRIEF.md
# Field-Aware FIFO DMA Request Generator

This block watches the fill level of a single capture FIFO and asks a DMA engine, by one-cycle request pulses, to drain it in bursts of double-words. Each burst is one threshold's worth of data. The threshold differs between the first and the second field of a frame. A programmable number of events per field decides which threshold governs each request and each burst. One request may be issued ahead of the burst in progress when the FIFO already holds enough data for both, so the DMA engine rarely waits for a fresh request.

The DMA engine reports every double-word it takes from the FIFO on a read strobe. The first strobe after a request starts that request's burst. A down-counter loaded with the burst's threshold then tracks the remaining data. A completion pulse marks the last word. A configuration input halves the thresholds, rounding up, so that one instance serves a luma FIFO and two more serve the chroma FIFOs. The read strobe has no back-pressure: it is a one-cycle event and is never stalled. A strobe that arrives when no burst is active or pending is flagged and otherwise dropped.

Top module: `dma_req_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `req_o`, `busy_o`, `done_o` and `rd_err_o` are 0.
- R2: With no request pending and no burst active, a FIFO level strictly greater than the threshold of the next event raises `req_o` for exactly one cycle, in the cycle after the level is sampled.
- R3: While a request is pending (raised, with its burst not yet started), no further request is raised at any FIFO level.
- R4: A read strobe with a request pending and no burst active starts that burst (`busy_o` = 1 next cycle). The burst ends after exactly as many strobes as the threshold of the burst's field, counting the first strobe. `done_o` pulses for one cycle and `busy_o` is 0 in the cycle after the last strobe.
- R5: While a burst is active and no request is pending, a request is raised when the level exceeds the sum of the active burst's threshold and the next event's threshold. When both belong to the same field, this is twice that field's threshold.
- R6: While the last field-1 event's burst is active and the next event is the first field-2 event, the request condition is level > field-1 threshold + field-2 threshold.
- R7: After the last field-1 burst has completed and a field-2 burst is active, the request condition for the next field-2 event is level > 2 × field-2 threshold.
- R8: Events with index 0 to `nevt_f1_i`-1 of a frame use the field-1 threshold, and the following `nevt_f2_i` events use the field-2 threshold. Once all events of a frame have been raised, no request is raised until the last burst completes. Counting then restarts at field 1.
- R9: With `chroma_i` = 1, every threshold in use is (T + T mod 2) / 2. With `chroma_i` = 0, T is used as given.
- R10: A read strobe with no burst active and no request pending gives a one-cycle `rd_err_o` pulse in the next cycle and changes no other state.
- R11: A burst whose threshold is 1 completes on its starting strobe: `done_o` = 1 and `busy_o` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_lvl_i | input | LVL_W | FIFO fill level in double-words |
| rd_stb_i | input | 1 | DMA engine took one double-word from the FIFO |
| thr_f1_i | input | THR_W | Field-1 burst threshold (at least 1) |
| thr_f2_i | input | THR_W | Field-2 burst threshold (at least 1) |
| nevt_f1_i | input | CNT_W | Number of field-1 events per frame |
| nevt_f2_i | input | CNT_W | Number of field-2 events per frame |
| chroma_i | input | 1 | 1: halve thresholds, rounding up |
| req_o | output | 1 | One-cycle DMA request pulse |
| busy_o | output | 1 | A burst is being serviced |
| done_o | output | 1 | One-cycle pulse when a burst completes |
| rd_err_o | output | 1 | One-cycle pulse for a strobe with nothing to service |

## Verification
Every output is a register. A level or strobe sampled at one clock edge therefore shows its result, whether a request, busy, done or error, in the cycle that follows that edge, and never later. The bench drives each stimulus at a falling edge, lets one rising edge pass, and compares all four outputs at the next falling edge. This keeps one-cycle pulses from being missed or seen twice. Burst lengths are checked by counting strobes until `done_o`, and threshold boundaries are probed at the level equal to the threshold and at one above it.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic {FLD_ONE = 1'b0, FLD_TWO = 1'b1} field_e;
endpackage

// File: rtl/dma_req_thr_scale.sv
// Threshold scaling: luma passes through, chroma halves with round-up.
module dma_req_thr_scale #(
  parameter int THR_W = 8
) (
  input  logic [THR_W-1:0] thr_i,
  input  logic             chroma_i,
  output logic [THR_W-1:0] thr_o
);
  logic [THR_W:0] rounded;

  always_comb begin
    rounded = {1'b0, thr_i} + {{THR_W{1'b0}}, thr_i[0]};
    thr_o   = chroma_i ? rounded[THR_W:1] : thr_i;
  end
endmodule

// File: rtl/dma_req_evt_track.sv
// Frame event bookkeeping: which field the next raised and the active event belong to.
module dma_req_evt_track
  import dma_req_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] nevt_f1_i,
  input  logic [CNT_W-1:0] nevt_f2_i,
  input  logic             raise_i,
  input  logic             finish_i,
  output field_e           next_fld_o,
  output field_e           svc_fld_o,
  output logic             can_raise_o
);
  localparam int IW = CNT_W + 1;

  logic [IW-1:0] raised_q, closed_q, total;

  always_comb begin
    total       = {1'b0, nevt_f1_i} + {1'b0, nevt_f2_i};
    next_fld_o  = (raised_q < {1'b0, nevt_f1_i}) ? FLD_ONE : FLD_TWO;
    svc_fld_o   = (closed_q < {1'b0, nevt_f1_i}) ? FLD_ONE : FLD_TWO;
    can_raise_o = raised_q < total;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raised_q <= '0;
      closed_q <= '0;
    end else if (finish_i && (closed_q + 1'b1 == total)) begin
      raised_q <= '0;
      closed_q <= '0;
    end else begin
      if (raise_i)  raised_q <= raised_q + 1'b1;
      if (finish_i) closed_q <= closed_q + 1'b1;
    end
  end
endmodule

// File: rtl/dma_req_svc_cnt.sv
// Outgoing data down-counter for the burst in service.
module dma_req_svc_cnt #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [THR_W-1:0] load_i,
  output logic             busy_o,
  output logic             finish_o
);
  logic [THR_W-1:0] left_q;
  logic             busy_q;

  always_comb begin
    finish_o = (start_i && load_i == THR_W'(1)) || (step_i && left_q == THR_W'(1));
    busy_o   = busy_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start_i) begin
      busy_q <= (load_i > THR_W'(1));
      left_q <= load_i - 1'b1;
    end else if (step_i) begin
      left_q <= left_q - 1'b1;
      if (left_q == THR_W'(1)) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int LVL_W = 10,
  parameter int THR_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_lvl_i,
  input  logic             rd_stb_i,
  input  logic [THR_W-1:0] thr_f1_i,
  input  logic [THR_W-1:0] thr_f2_i,
  input  logic [CNT_W-1:0] nevt_f1_i,
  input  logic [CNT_W-1:0] nevt_f2_i,
  input  logic             chroma_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             rd_err_o
);
  localparam int SUM_W = THR_W + 1;
  localparam int CW    = ((LVL_W > SUM_W) ? LVL_W : SUM_W) + 1;

  logic [THR_W-1:0] thr_raw [2];
  logic [THR_W-1:0] thr_eff [2];
  logic [THR_W-1:0] t_next, t_svc;
  logic [CW-1:0]    lvl_x, lim_idle, lim_ahead;
  field_e           next_fld, svc_fld;
  logic             can_raise, pend_q, svc_busy, finish;
  logic             raise, start, step;

  assign thr_raw[0] = thr_f1_i;
  assign thr_raw[1] = thr_f2_i;

  for (genvar f = 0; f < 2; f++) begin : g_scale
    dma_req_thr_scale #(.THR_W(THR_W)) u_scale (
      .thr_i(thr_raw[f]), .chroma_i(chroma_i), .thr_o(thr_eff[f]));
  end

  dma_req_evt_track #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .nevt_f1_i(nevt_f1_i), .nevt_f2_i(nevt_f2_i),
    .raise_i(raise), .finish_i(finish), .next_fld_o(next_fld),
    .svc_fld_o(svc_fld), .can_raise_o(can_raise));

  dma_req_svc_cnt #(.THR_W(THR_W)) u_svc (
    .clk(clk), .rst_n(rst_n), .start_i(start), .step_i(step),
    .load_i(t_svc), .busy_o(svc_busy), .finish_o(finish));

  always_comb begin
    t_next    = (next_fld == FLD_ONE) ? thr_eff[0] : thr_eff[1];
    t_svc     = (svc_fld  == FLD_ONE) ? thr_eff[0] : thr_eff[1];
    lvl_x     = CW'(fifo_lvl_i);
    lim_idle  = CW'(t_next);
    lim_ahead = CW'(t_next) + CW'(t_svc);
    raise     = can_raise && !pend_q &&
                (svc_busy ? (lvl_x > lim_ahead) : (lvl_x > lim_idle));
    start     = rd_stb_i && !svc_busy && pend_q;
    step      = rd_stb_i && svc_busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      req_o    <= 1'b0;
      done_o   <= 1'b0;
      rd_err_o <= 1'b0;
    end else begin
      if (raise)      pend_q <= 1'b1;
      else if (start) pend_q <= 1'b0;
      req_o    <= raise;
      done_o   <= finish;
      rd_err_o <= rd_stb_i && !svc_busy && !pend_q;
    end
  end

  assign busy_o = svc_busy;
endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic busy,
  input logic done,
  input logic err,
  input logic pend
);
  // R2
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R3
  req_not_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(!pend));
  // R4
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R4
  busy_rise_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pend));
  // R10
  err_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(!busy && !pend));
  // R10
  err_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
endmodule

bind dma_req_gen dma_req_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req_o), .busy(busy_o),
  .done(done_o), .err(rd_err_o), .pend(pend_q));

// File: tb/sim_dma_req_gen.sv
`timescale 1ns/1ps
module sim_dma_req_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] lvl = '0;
  logic       rd = 1'b0;
  logic [7:0] t1 = 8'd4, t2 = 8'd6;
  logic [3:0] n1 = 4'd2, n2 = 4'd1;
  logic       chroma = 1'b0;
  logic       req, busy, done, err;
  int         checks = 0, failures = 0;
  bit         finished = 0;

  always #2.5 clk = ~clk;

  dma_req_gen u0 (
    .clk(clk), .rst_n(rst_n), .fifo_lvl_i(lvl), .rd_stb_i(rd),
    .thr_f1_i(t1), .thr_f2_i(t2), .nevt_f1_i(n1), .nevt_f2_i(n2),
    .chroma_i(chroma), .req_o(req), .busy_o(busy), .done_o(done), .rd_err_o(err));

  // {tag[18:15], level[14:5], rd[4], req, busy, done, err}; thr 4/6, events 2/1, luma
  localparam logic [18:0] VEC [25] = '{
    {4'd2, 10'd4,  1'b0, 4'b0000},  // R2 level equal to threshold
    {4'd2, 10'd5,  1'b0, 4'b1000},  // R2 level above threshold
    {4'd3, 10'd9,  1'b0, 4'b0000},  // R3 pending blocks
    {4'd4, 10'd9,  1'b1, 4'b0100},  // R4 first strobe starts burst
    {4'd5, 10'd8,  1'b0, 4'b0100},  // R5 2x4 not exceeded
    {4'd5, 10'd9,  1'b1, 4'b1100},  // R5 2x4 exceeded
    {4'd3, 10'd20, 1'b1, 4'b0100},  // R3
    {4'd4, 10'd20, 1'b1, 4'b0010},  // R4 fourth strobe ends burst
    {4'd3, 10'd20, 1'b0, 4'b0000},  // R3
    {4'd4, 10'd0,  1'b1, 4'b0100},  // R4 last field-1 burst starts
    {4'd6, 10'd10, 1'b0, 4'b0100},  // R6 4+6 not exceeded
    {4'd6, 10'd11, 1'b0, 4'b1100},  // R6 4+6 exceeded
    {4'd4, 10'd30, 1'b1, 4'b0100},  // R4
    {4'd4, 10'd30, 1'b1, 4'b0100},  // R4
    {4'd4, 10'd30, 1'b1, 4'b0010},  // R4
    {4'd4, 10'd30, 1'b1, 4'b0100},  // R4 field-2 burst, 6 long
    {4'd8, 10'd30, 1'b0, 4'b0100},  // R8 all events raised
    {4'd4, 10'd30, 1'b1, 4'b0100},  // R4
    {4'd4, 10'd30, 1'b1, 4'b0100},  // R4
    {4'd4, 10'd30, 1'b1, 4'b0100},  // R4
    {4'd4, 10'd30, 1'b1, 4'b0100},  // R4
    {4'd4, 10'd30, 1'b1, 4'b0010},  // R4 sixth strobe
    {4'd8, 10'd30, 1'b0, 4'b1000},  // R8 new frame at field 1
    {4'd3, 10'd30, 1'b0, 4'b0000},  // R3
    {4'd4, 10'd0,  1'b1, 4'b0100}   // R4
  };

  task automatic check(input string tag, input logic [3:0] exp);
    checks++;
    if ({req, busy, done, err} !== exp) begin
      failures++;
      $display("FAIL %s: got req/busy/done/err=%b expected %b", tag, {req, busy, done, err}, exp);
    end
  endtask

  task automatic apply(input logic [9:0] l, input logic r);
    lvl = l; rd = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart(input logic [7:0] a, input logic [7:0] b,
                         input logic [3:0] na, input logic [3:0] nb, input logic ch);
    rst_n = 1'b0; lvl = '0; rd = 1'b0;
    t1 = a; t2 = b; n1 = na; n2 = nb; chroma = ch;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    restart(8'd4, 8'd6, 4'd2, 4'd1, 1'b0);
    check("R1 in reset", 4'b0000);
    @(negedge clk);
    check("R1 after release", 4'b0000);

    for (int i = 0; i < 25; i++) begin
      apply(VEC[i][14:5], VEC[i][4]);
      check($sformatf("R%0d vector %0d", VEC[i][18:15], i), VEC[i][3:0]);
    end

    // R10 stray strobe flagged, leaves no pending request
    restart(8'd4, 8'd6, 4'd2, 4'd1, 1'b0);
    @(negedge clk);
    apply(10'd0, 1'b1); check("R10 stray strobe", 4'b0001);
    apply(10'd0, 1'b0); check("R10 pulse ends", 4'b0000);
    apply(10'd5, 1'b0); check("R10 no phantom pending", 4'b1000);

    // R7 field-2 ahead rule after last field-1 completes (thr 4/3, events 1/2)
    restart(8'd4, 8'd3, 4'd1, 4'd2, 1'b0);
    @(negedge clk);
    apply(10'd5, 1'b0); check("R2 first", 4'b1000);
    apply(10'd0, 1'b1); check("R4 start", 4'b0100);
    apply(10'd7, 1'b0); check("R6 equal sum", 4'b0100);
    apply(10'd8, 1'b0); check("R6 above sum", 4'b1100);
    apply(10'd0, 1'b1); apply(10'd0, 1'b1);
    apply(10'd0, 1'b1); check("R4 field-1 done", 4'b0010);
    apply(10'd0, 1'b1); check("R4 field-2 start", 4'b0100);
    apply(10'd6, 1'b0); check("R7 equal 2x", 4'b0100);
    apply(10'd7, 1'b0); check("R7 above 2x", 4'b1100);

    // R9 chroma scaling: 5 -> 3
    restart(8'd5, 8'd5, 4'd1, 4'd1, 1'b1);
    @(negedge clk);
    apply(10'd3, 1'b0); check("R9 equal scaled", 4'b0000);
    apply(10'd4, 1'b0); check("R9 above scaled", 4'b1000);
    apply(10'd0, 1'b1); check("R9 start", 4'b0100);
    apply(10'd0, 1'b1); check("R9 second strobe", 4'b0100);
    apply(10'd0, 1'b1); check("R9 third strobe done", 4'b0010);

    // R11 threshold of one
    restart(8'd1, 8'd2, 4'd1, 4'd1, 1'b0);
    @(negedge clk);
    apply(10'd2, 1'b0); check("R11 request", 4'b1000);
    apply(10'd0, 1'b1); check("R11 single strobe done", 4'b0010);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule